// File: doc/BRIEF.md
# VLAN IPv4 UDP Tunnel Header Generator

This block produces the 46-byte outer header that wraps a packet for transport through a UDP tunnel. The header has three parts: an 18-byte tagged Ethernet header, a 20-byte IPv4 header and an 8-byte UDP header. The block sends the header out as a byte stream in network byte order, one byte per clock, with valid, first and last markers. A downstream writer places the bytes in front of the payload.

Static settings arrive on plain input ports and stay constant between packets: the local MAC and IP addresses, the peer MAC and IP addresses, and the UDP source and destination ports. A single register holds a folded ones-complement sum over every IPv4 header word that depends only on these settings. That register refreshes from the settings on each clock. For each packet, the block adds the total-length word to this partial sum to form the header checksum. A start pulse captures the per-packet inputs, which are the slice VLAN identifier and the payload length.

Top module: `tunnel_hdr_gen`

## Requirements
- R1: While reset is high and in the cycle after it is released, `hdr_valid`, `hdr_first` and `hdr_last` are low.
- R2: A `start` sampled while no header is in progress makes `hdr_valid` high for exactly 46 consecutive cycles, beginning in the next cycle. `hdr_first` is high only with byte 0 and `hdr_last` only with byte 45. `hdr_valid` drops in the cycle after byte 45.
- R3: A `start` sampled while a header is being emitted is ignored, including during the cycle of byte 45. The stream in progress does not restart, and no new header begins afterwards.
- R4: Bytes 0-5 are the peer MAC and bytes 6-11 the local MAC, most significant byte first. Bytes 12-13 are 0x81,0x00. Bytes 14-15 are the 16-bit tag field, which holds the slice identifier zero-extended. Bytes 16-17 are 0x08,0x00.
- R5: Byte 18 is 0x45 and byte 19 is 0x00. Bytes 22-25 are zero. Byte 26 is 64 and byte 27 is 17. Bytes 30-33 are the local IP and bytes 34-37 are the peer IP, most significant byte first.
- R6: Bytes 20-21 carry the payload length plus 28, big-endian.
- R7: Bytes 28-29 carry the IPv4 header checksum. It is the ones-complement of the ones-complement sum of the ten 16-bit header words with the checksum word taken as zero. Summing all ten emitted words with end-around carry therefore gives 0xFFFF.
- R8: Bytes 38-39 are the UDP source port and bytes 40-41 the destination port. Bytes 42-43 carry the payload length plus 8. Bytes 44-45 are zero.
- R9: The slice identifier and payload length are captured when `start` is accepted. Changing them while a header is being emitted does not alter the bytes.
- R10: Static settings that change and then stay stable for one cycle before `start` is sampled are fully reflected in the next header, including its checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_local_mac | input | 48 | Local MAC address (Ethernet source) |
| cfg_local_ip | input | 32 | Local IPv4 address (IP source) |
| cfg_peer_mac | input | 48 | Peer MAC address (Ethernet destination) |
| cfg_peer_ip | input | 32 | Peer IPv4 address (IP destination) |
| cfg_src_port | input | 16 | UDP source port |
| cfg_dst_port | input | 16 | UDP destination port |
| start | input | 1 | Request one header |
| slice_vid | input | VID_W | Slice identifier placed in the tag field |
| payload_len | input | LEN_W | Bytes carried after the UDP header |
| hdr_valid | output | 1 | A header byte is present |
| hdr_first | output | 1 | Marks byte 0 |
| hdr_last | output | 1 | Marks byte 45 |
| hdr_byte | output | 8 | Header byte |

## Verification
The bench uses the default widths: a 12-bit slice identifier and a 16-bit payload length. It sweeps four sets of static settings against twenty payload lengths and several slice identifiers. The settings include all-zero and all-ones addresses, so the checksum sees both no carry and the maximum end-around carry. The lengths include 0, small values, byte-boundary values and the largest legal IPv4 payload.

Every byte is compared against a header that the bench assembles arithmetically. Every checksum is also verified by re-summing the received words. Some packets use a disturbed run, in which the per-packet inputs change and `start` pulses mid-header and on the last byte. These runs reach the capture and ignore paths.

// File: rtl/tunnel_hdr_pkg.sv
package tunnel_hdr_pkg;

    localparam int ETH_BYTES = 18;
    localparam int IP_BYTES  = 20;
    localparam int UDP_BYTES = 8;
    localparam int HDR_BYTES = ETH_BYTES + IP_BYTES + UDP_BYTES;
    localparam int IDX_W     = $clog2(HDR_BYTES);

    localparam logic [15:0] TAG_TYPE   = 16'h8100;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  VER_IHL    = 8'h45;
    localparam logic [7:0]  TOS_VAL    = 8'h00;
    localparam logic [7:0]  TTL_VAL    = 8'd64;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;
    localparam logic [15:0] IP_OVH     = 16'(IP_BYTES + UDP_BYTES);
    localparam logic [15:0] UDP_OVH    = 16'(UDP_BYTES);

    typedef struct packed {
        logic [47:0] local_mac;
        logic [31:0] local_ip;
        logic [47:0] peer_mac;
        logic [31:0] peer_ip;
        logic [15:0] src_port;
        logic [15:0] dst_port;
    } cfg_t;

    typedef struct packed {
        logic [15:0] tag_field;
        logic [15:0] ip_len;
        logic [15:0] udp_len;
        logic [15:0] ip_csum;
    } pkt_t;

    // End-around carry fold of a 32-bit sum into 16 bits; two passes suffice.
    function automatic logic [15:0] fold16(input logic [31:0] s);
        logic [16:0] t;
        logic [16:0] u;
        t = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        u = {1'b0, t[15:0]} + {16'b0, t[16]};
        return u[15:0];
    endfunction

endpackage

// File: rtl/tunnel_csum_pre.sv
module tunnel_csum_pre
    import tunnel_hdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cfg_t        cfg,
    output logic [15:0] partial
);
    logic [31:0] static_sum;

    always_comb begin
        static_sum = {16'b0, VER_IHL, TOS_VAL}
                   + {16'b0, TTL_VAL, PROTO_UDP}
                   + {16'b0, cfg.local_ip[31:16]}
                   + {16'b0, cfg.local_ip[15:0]}
                   + {16'b0, cfg.peer_ip[31:16]}
                   + {16'b0, cfg.peer_ip[15:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) partial <= '0;
        else     partial <= fold16(static_sum);
    end
endmodule

// File: rtl/tunnel_hdr_seq.sv
module tunnel_hdr_seq
    import tunnel_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             accept,
    output logic [IDX_W-1:0] idx,
    output logic             valid,
    output logic             first,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

    logic busy;

    assign accept = start && !busy;
    assign valid  = busy;
    assign first  = busy && (idx == '0);
    assign last   = busy && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST_IDX) busy <= 1'b0;
            else                 idx  <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/tunnel_hdr_mux.sv
module tunnel_hdr_mux
    import tunnel_hdr_pkg::*;
(
    input  cfg_t             cfg,
    input  pkt_t             pkt,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data
);
    logic [8*HDR_BYTES-1:0] image;
    logic [7:0]             bytes [HDR_BYTES];

    assign image = {cfg.peer_mac, cfg.local_mac, TAG_TYPE, pkt.tag_field, ETYPE_IPV4,
                    VER_IHL, TOS_VAL, pkt.ip_len, 32'h0, TTL_VAL, PROTO_UDP, pkt.ip_csum,
                    cfg.local_ip, cfg.peer_ip,
                    cfg.src_port, cfg.dst_port, pkt.udp_len, 16'h0};

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_slice
        assign bytes[g] = image[8*(HDR_BYTES-1-g) +: 8];
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (idx == IDX_W'(i)) data = bytes[i];
        end
    end
endmodule

// File: rtl/tunnel_hdr_gen.sv
module tunnel_hdr_gen
    import tunnel_hdr_pkg::*;
#(
    parameter int VID_W = 12,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [47:0]      cfg_local_mac,
    input  logic [31:0]      cfg_local_ip,
    input  logic [47:0]      cfg_peer_mac,
    input  logic [31:0]      cfg_peer_ip,
    input  logic [15:0]      cfg_src_port,
    input  logic [15:0]      cfg_dst_port,
    input  logic             start,
    input  logic [VID_W-1:0] slice_vid,
    input  logic [LEN_W-1:0] payload_len,
    output logic             hdr_valid,
    output logic             hdr_first,
    output logic             hdr_last,
    output logic [7:0]       hdr_byte
);
    cfg_t             cfg;
    pkt_t             pkt_q;
    pkt_t             pkt_d;
    logic [15:0]      partial;
    logic             accept;
    logic [IDX_W-1:0] idx;
    logic [15:0]      len16;
    logic [31:0]      csum_sum;

    assign cfg = '{local_mac: cfg_local_mac, local_ip: cfg_local_ip,
                   peer_mac: cfg_peer_mac, peer_ip: cfg_peer_ip,
                   src_port: cfg_src_port, dst_port: cfg_dst_port};

    tunnel_csum_pre u_pre (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .partial (partial)
    );

    always_comb begin
        len16             = 16'(payload_len);
        pkt_d.tag_field   = 16'(slice_vid);
        pkt_d.ip_len      = len16 + IP_OVH;
        pkt_d.udp_len     = len16 + UDP_OVH;
        csum_sum          = {16'b0, partial} + {16'b0, pkt_d.ip_len};
        pkt_d.ip_csum     = ~fold16(csum_sum);
    end

    always_ff @(posedge clk) begin
        if (rst)         pkt_q <= '0;
        else if (accept) pkt_q <= pkt_d;
    end

    tunnel_hdr_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .idx    (idx),
        .valid  (hdr_valid),
        .first  (hdr_first),
        .last   (hdr_last)
    );

    tunnel_hdr_mux u_mux (
        .cfg  (cfg),
        .pkt  (pkt_q),
        .idx  (idx),
        .data (hdr_byte)
    );
endmodule

// File: rtl/tunnel_hdr_gen_chk.sv
module tunnel_hdr_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [47:0] cfg_peer_mac,
    input logic        hdr_valid,
    input logic        hdr_first,
    input logic        hdr_last,
    input logic [7:0]  hdr_byte
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !hdr_valid && !hdr_first && !hdr_last);

    // R2
    first_in_frame_chk: assert property (@(posedge clk) disable iff (rst) hdr_first |-> hdr_valid);

    // R2
    last_in_frame_chk: assert property (@(posedge clk) disable iff (rst) hdr_last |-> hdr_valid);

    // R2
    idle_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !hdr_valid) |=> hdr_valid && hdr_first);

    // R2
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !hdr_last) |=> hdr_valid && !hdr_first);

    // R3
    end_after_last_chk: assert property (@(posedge clk) disable iff (rst) hdr_last |=> !hdr_valid);

    // R4
    lead_byte_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_first |-> hdr_byte == cfg_peer_mac[47:40]);
endmodule

bind tunnel_hdr_gen tunnel_hdr_gen_chk u_chk (.*);

// File: tb/tunnel_hdr_gen_bench.sv
module tunnel_hdr_gen_bench;
    localparam int NB = 46;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] cfg_local_mac = '0;
    logic [31:0] cfg_local_ip  = '0;
    logic [47:0] cfg_peer_mac  = '0;
    logic [31:0] cfg_peer_ip   = '0;
    logic [15:0] cfg_src_port  = '0;
    logic [15:0] cfg_dst_port  = '0;
    logic        start = 1'b0;
    logic [11:0] slice_vid = '0;
    logic [15:0] payload_len = '0;
    logic        hdr_valid, hdr_first, hdr_last;
    logic [7:0]  hdr_byte;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    logic [7:0] exp_b [NB];
    logic [7:0] rx_b  [NB];

    always #4 clk = ~clk;

    tunnel_hdr_gen u_tunnel_hdr_gen (
        .clk(clk), .rst(rst),
        .cfg_local_mac(cfg_local_mac), .cfg_local_ip(cfg_local_ip),
        .cfg_peer_mac(cfg_peer_mac), .cfg_peer_ip(cfg_peer_ip),
        .cfg_src_port(cfg_src_port), .cfg_dst_port(cfg_dst_port),
        .start(start), .slice_vid(slice_vid), .payload_len(payload_len),
        .hdr_valid(hdr_valid), .hdr_first(hdr_first), .hdr_last(hdr_last),
        .hdr_byte(hdr_byte)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ocsum(input logic [31:0] s);
        logic [31:0] t = s;
        while (t > 32'hFFFF) t = (t & 32'hFFFF) + (t >> 16);
        return t[15:0];
    endfunction

    task automatic build(input logic [11:0] vid, input logic [15:0] len);
        logic [15:0] tot;
        logic [15:0] ulen;
        logic [31:0] s;
        logic [15:0] ck;
        tot  = len + 16'd28;
        ulen = len + 16'd8;
        for (int i = 0; i < 6; i++) begin
            exp_b[i]     = cfg_peer_mac[47-8*i -: 8];
            exp_b[6 + i] = cfg_local_mac[47-8*i -: 8];
        end
        exp_b[12] = 8'h81; exp_b[13] = 8'h00;
        exp_b[14] = {4'h0, vid[11:8]}; exp_b[15] = vid[7:0];
        exp_b[16] = 8'h08; exp_b[17] = 8'h00;
        exp_b[18] = 8'h45; exp_b[19] = 8'h00;
        exp_b[20] = tot[15:8]; exp_b[21] = tot[7:0];
        for (int i = 22; i < 26; i++) exp_b[i] = 8'h00;
        exp_b[26] = 8'd64; exp_b[27] = 8'd17;
        for (int i = 0; i < 4; i++) begin
            exp_b[30 + i] = cfg_local_ip[31-8*i -: 8];
            exp_b[34 + i] = cfg_peer_ip[31-8*i -: 8];
        end
        exp_b[38] = cfg_src_port[15:8]; exp_b[39] = cfg_src_port[7:0];
        exp_b[40] = cfg_dst_port[15:8]; exp_b[41] = cfg_dst_port[7:0];
        exp_b[42] = ulen[15:8]; exp_b[43] = ulen[7:0];
        exp_b[44] = 8'h00; exp_b[45] = 8'h00;
        s = 0;
        for (int w = 0; w < 10; w++)
            if (w != 5) s += {16'b0, exp_b[18 + 2*w], exp_b[19 + 2*w]};
        ck = ~ocsum(s);
        exp_b[28] = ck[15:8]; exp_b[29] = ck[7:0];
    endtask

    function automatic string tag_of(input int i);
        if (i < 18)                     return "R4";
        if (i == 20 || i == 21)         return "R6";
        if (i == 28 || i == 29)         return "R7";
        if (i >= 38)                    return "R8";
        return "R5";
    endfunction

    task automatic run_pkt(input logic [11:0] vid, input logic [15:0] len,
                           input bit disturb, input bit after_cfg);
        logic [31:0] s;
        build(vid, len);
        slice_vid = vid; payload_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            slice_vid = ~vid; payload_len = len ^ 16'h5555;
        end
        for (int i = 0; i < NB; i++) begin
            rx_b[i] = hdr_byte;
            chk(hdr_byte == exp_b[i],
                disturb ? "R9" : (after_cfg && (i == 28 || i == 29)) ? "R10" : tag_of(i),
                $sformatf("byte %0d", i), {24'b0, hdr_byte}, {24'b0, exp_b[i]});
            chk(hdr_valid && (hdr_first == (i == 0)) && (hdr_last == (i == NB - 1)),
                disturb ? "R3" : "R2", $sformatf("markers at byte %0d", i),
                {29'b0, hdr_valid, hdr_first, hdr_last},
                {29'b0, 1'b1, i == 0, i == NB - 1});
            if (disturb && i == 20) start = 1'b1;
            if (disturb && i == 21) start = 1'b0;
            if (disturb && i == NB - 1) start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        chk(!hdr_valid, disturb ? "R3" : "R2", "valid after last byte",
            {31'b0, hdr_valid}, 32'h0);
        s = 0;
        for (int w = 0; w < 10; w++) s += {16'b0, rx_b[18 + 2*w], rx_b[19 + 2*w]};
        chk(ocsum(s) == 16'hFFFF, after_cfg ? "R10" : "R7", "received header sum",
            {16'b0, ocsum(s)}, 32'hFFFF);
    endtask

    task automatic set_cfg(input int k);
        case (k)
            0: begin
                cfg_local_mac = '0; cfg_peer_mac = '0; cfg_local_ip = '0; cfg_peer_ip = '0;
                cfg_src_port = '0; cfg_dst_port = '0;
            end
            1: begin
                cfg_local_mac = '1; cfg_peer_mac = '1; cfg_local_ip = '1; cfg_peer_ip = '1;
                cfg_src_port = '1; cfg_dst_port = '1;
            end
            2: begin
                cfg_local_mac = 48'h02_11_22_33_44_55; cfg_peer_mac = 48'h0A_BB_CC_DD_EE_F1;
                cfg_local_ip = 32'hC0A8_0001; cfg_peer_ip = 32'h0A00_00FE;
                cfg_src_port = 16'd4789; cfg_dst_port = 16'd51000;
            end
            default: begin
                cfg_local_mac = 48'hFE_DC_BA_98_76_54; cfg_peer_mac = 48'h13_57_9B_DF_24_68;
                cfg_local_ip = 32'hFFFE_8001; cfg_peer_ip = 32'hF00F_7FFF;
                cfg_src_port = 16'h8001; cfg_dst_port = 16'h00FF;
            end
        endcase
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lens [20];
        logic [11:0] vid;
        lens = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd7, 16'd8, 16'd15, 16'd18,
                 16'd46, 16'd100, 16'd227, 16'd228, 16'd255, 16'd256, 16'd1000,
                 16'd1472, 16'd9000, 16'd65507};
        @(negedge clk);
        chk(!hdr_valid && !hdr_first && !hdr_last, "R1", "flags in reset",
            {29'b0, hdr_valid, hdr_first, hdr_last}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!hdr_valid && !hdr_first && !hdr_last, "R1", "flags after reset",
            {29'b0, hdr_valid, hdr_first, hdr_last}, 32'h0);
        for (int k = 0; k < 4; k++) begin
            set_cfg(k);
            @(negedge clk);
            for (int j = 0; j < 20; j++) begin
                vid = (j == 0) ? 12'h000 : (j == 1) ? 12'hFFF : 12'(j * 211 + k);
                run_pkt(vid, lens[j], (j % 5) == 4, j == 0);
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule